// File: doc/BRIEF.md
# SPI Control-Register Access Slave

This block is the serial front end of a bank of 32 byte-wide control registers. An SPI master opens a transaction by pulling slave select low and sends 8-bit words, most significant bit first. The first word of a transaction is a header. It either names a direct command, which leaves the block as a one-cycle strobe with a 5-bit code, or it names a register address together with a read/write choice and an access mode.

In single-address mode every data word is followed by a fresh header, so a master can reach scattered registers in one transaction. In continuous mode the header is followed by any number of data words that go to consecutive addresses, and the address wraps from 31 back to 0. Read data leaves on MISO from the same register port that takes writes. A strobe marks each read whose target register clears itself when read, and the register file owner performs that clear.

All SPI inputs are resynchronised into the system clock domain. For this reason SCLK must stay in each phase for several system clock cycles. SCLK idles low. MOSI is taken on the rising edge and MISO moves after the falling edge.

Top module: `spi_reg_slave`

## Requirements
- R1: Each word is assembled from 8 MOSI bits taken on SCLK rising edges, first bit into bit 7. A write data word raises `reg_we_o` for exactly one cycle, with `reg_addr_o` set to the addressed register and `reg_wdata_o` set to the word.
- R2: A header with bit 7 = 1 raises `cmd_valid_o` for one cycle, with `cmd_code_o` = header bits 4:0. The remaining words of that transaction cause no register write and no further command.
- R3: A header with bit 7 = 0 carries the address in bits 4:0, read in bit 6 (1 = read, 0 = write) and continuous mode in bit 5 (1 = continuous). In single-address mode (bit 5 = 0) one data word follows the header, and the next word is decoded again as a header.
- R4: In continuous mode the data words of the transaction go to addresses x, x+1, x+2, and so on, wrapping from 0x1F to 0x00.
- R5: For a read, the addressed register's byte is shifted out on MISO with bit 7 first. It becomes valid after the SCLK falling edge that ends the preceding word, and MISO never changes while SCLK is high.
- R6: Each register fetch raises `reg_re_o` for one cycle. `rd_clr_o` rises with it only when bit `reg_addr_o` of parameter `CLR_MASK` is set; the default mask marks addresses 0x0C and 0x0F.
- R7: Raising slave select ends the transaction. A word that is not yet complete is discarded, causes no write, and the next transaction starts with a header.
- R8: After reset `reg_we_o`, `reg_re_o`, `cmd_valid_o`, `rd_clr_o` and `miso_o` are low.
- R9: At most one of `reg_we_o`, `reg_re_o` and `cmd_valid_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | SPI clock, idles low |
| cs_ni | input | 1 | Slave select, active low |
| mosi_i | input | 1 | Serial data from master |
| miso_o | output | 1 | Serial data to master |
| reg_we_o | output | 1 | Register write strobe |
| reg_re_o | output | 1 | Register fetch strobe |
| rd_clr_o | output | 1 | Clear-on-read strobe for the fetched register |
| reg_addr_o | output | 5 | Register address |
| reg_wdata_o | output | 8 | Register write data |
| reg_rdata_i | input | 8 | Register read data, combinational from reg_addr_o |
| cmd_valid_o | output | 1 | Direct command strobe |
| cmd_code_o | output | 5 | Direct command code |

## Verification
After the SCLK rising edge that completes a word, the resulting strobe appears SYNC_STAGES+2 system cycles later. This covers two synchroniser flops, the word-complete register and the strobe register. MISO follows an SCLK falling edge after SYNC_STAGES+1 cycles. The bench holds each SCLK phase for 10 system cycles and drives and samples only on falling system clock edges. This means MISO is read at each SCLK rising edge, long after it settled, and the register model is compared only after slave select has been high for several SCLK half periods. A monitor counts any MISO transition while SCLK is high, and any cycle with more than one strobe high.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int unsigned WORD_W   = 8;
  localparam int unsigned ADDR_W   = 5;
  localparam int unsigned N_REGS   = 1 << ADDR_W;
  localparam int unsigned CMD_BIT  = 7;
  localparam int unsigned RD_BIT   = 6;
  localparam int unsigned CONT_BIT = 5;
  localparam int unsigned CNT_W    = $clog2(WORD_W);

  typedef enum logic [1:0] {
    ST_HDR,
    ST_WDATA,
    ST_RDATA,
    ST_SKIP
  } txn_state_e;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni,
  input  logic mosi_i,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic cs_active_o,
  output logic mosi_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] sclk_p, cs_p, mosi_p;
  logic              sclk_d;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          sclk_p <= '0;
          cs_p   <= '1;
          mosi_p <= '0;
        end else begin
          sclk_p <= sclk_i;
          cs_p   <= cs_ni;
          mosi_p <= mosi_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          sclk_p <= '0;
          cs_p   <= '1;
          mosi_p <= '0;
        end else begin
          sclk_p <= {sclk_p[STAGES-2:0], sclk_i};
          cs_p   <= {cs_p[STAGES-2:0], cs_ni};
          mosi_p <= {mosi_p[STAGES-2:0], mosi_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d <= 1'b0;
    else         sclk_d <= sclk_p[LAST];
  end

  assign sclk_rise_o = sclk_p[LAST] & ~sclk_d;
  assign sclk_fall_o = ~sclk_p[LAST] & sclk_d;
  assign cs_active_o = ~cs_p[LAST];
  assign mosi_o      = mosi_p[LAST];
endmodule

// File: rtl/spi_word_shift.sv
module spi_word_shift
  import spi_reg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_active_i,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  input  logic              mosi_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] load_data_i,
  output logic              word_done_o,
  output logic [WORD_W-1:0] word_o,
  output logic              miso_o
);
  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] rx_sh, tx_sh;
  logic [WORD_W-1:0] rx_next;

  assign rx_next = {rx_sh[WORD_W-2:0], mosi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt     <= '0;
      rx_sh       <= '0;
      word_o      <= '0;
      word_done_o <= 1'b0;
    end else begin
      word_done_o <= 1'b0;
      if (!cs_active_i) begin
        bit_cnt <= '0;
        rx_sh   <= '0;
      end else if (sclk_rise_i) begin
        rx_sh   <= rx_next;
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == CNT_W'(WORD_W - 1)) begin
          word_o      <= rx_next;
          word_done_o <= 1'b1;
        end
      end
    end
  end

  // MISO moves only after a detected falling edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sh  <= '0;
      miso_o <= 1'b0;
    end else if (!cs_active_i) begin
      tx_sh  <= '0;
      miso_o <= 1'b0;
    end else if (load_i) begin
      tx_sh <= load_data_i;
    end else if (sclk_fall_i) begin
      miso_o <= tx_sh[WORD_W-1];
      tx_sh  <= {tx_sh[WORD_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/spi_txn_ctrl.sv
module spi_txn_ctrl
  import spi_reg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_active_i,
  input  logic              word_done_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              reg_we_o,
  output logic              reg_re_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [WORD_W-1:0] reg_wdata_o,
  output logic              cmd_valid_o,
  output logic [ADDR_W-1:0] cmd_code_o
);
  txn_state_e state_q;
  logic       cont_q;
  logic       inc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_HDR;
      cont_q      <= 1'b0;
      inc_q       <= 1'b0;
      reg_we_o    <= 1'b0;
      reg_re_o    <= 1'b0;
      reg_addr_o  <= '0;
      reg_wdata_o <= '0;
      cmd_valid_o <= 1'b0;
      cmd_code_o  <= '0;
    end else begin
      reg_we_o    <= 1'b0;
      reg_re_o    <= 1'b0;
      cmd_valid_o <= 1'b0;
      inc_q       <= 1'b0;
      // post-write increment keeps the address steady during the strobe
      if (inc_q) reg_addr_o <= reg_addr_o + 1'b1;
      if (!cs_active_i) begin
        state_q <= ST_HDR;
      end else if (word_done_i) begin
        case (state_q)
          ST_HDR: begin
            if (word_i[CMD_BIT]) begin
              cmd_valid_o <= 1'b1;
              cmd_code_o  <= word_i[ADDR_W-1:0];
              state_q     <= ST_SKIP;
            end else begin
              reg_addr_o <= word_i[ADDR_W-1:0];
              cont_q     <= word_i[CONT_BIT];
              if (word_i[RD_BIT]) begin
                reg_re_o <= 1'b1;
                state_q  <= ST_RDATA;
              end else begin
                state_q  <= ST_WDATA;
              end
            end
          end
          ST_WDATA: begin
            reg_we_o    <= 1'b1;
            reg_wdata_o <= word_i;
            inc_q       <= cont_q;
            if (!cont_q) state_q <= ST_HDR;
          end
          ST_RDATA: begin
            if (cont_q) begin
              reg_addr_o <= reg_addr_o + 1'b1;
              reg_re_o   <= 1'b1;
            end else begin
              state_q <= ST_HDR;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int unsigned        SYNC_STAGES = 2,
  parameter logic [N_REGS-1:0]  CLR_MASK    = 32'h0000_9000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              reg_we_o,
  output logic              reg_re_o,
  output logic              rd_clr_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [WORD_W-1:0] reg_wdata_o,
  input  logic [WORD_W-1:0] reg_rdata_i,
  output logic              cmd_valid_o,
  output logic [ADDR_W-1:0] cmd_code_o
);
  logic              sclk_rise, sclk_fall, cs_active, mosi_s;
  logic              word_done;
  logic [WORD_W-1:0] word;

  spi_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_i      (sclk_i),
    .cs_ni       (cs_ni),
    .mosi_i      (mosi_i),
    .sclk_rise_o (sclk_rise),
    .sclk_fall_o (sclk_fall),
    .cs_active_o (cs_active),
    .mosi_o      (mosi_s)
  );

  spi_word_shift u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_active_i (cs_active),
    .sclk_rise_i (sclk_rise),
    .sclk_fall_i (sclk_fall),
    .mosi_i      (mosi_s),
    .load_i      (reg_re_o),
    .load_data_i (reg_rdata_i),
    .word_done_o (word_done),
    .word_o      (word),
    .miso_o      (miso_o)
  );

  spi_txn_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_active_i (cs_active),
    .word_done_i (word_done),
    .word_i      (word),
    .reg_we_o    (reg_we_o),
    .reg_re_o    (reg_re_o),
    .reg_addr_o  (reg_addr_o),
    .reg_wdata_o (reg_wdata_o),
    .cmd_valid_o (cmd_valid_o),
    .cmd_code_o  (cmd_code_o)
  );

  assign rd_clr_o = reg_re_o & CLR_MASK[reg_addr_o];
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_ni,
  input logic reg_we_o,
  input logic reg_re_o,
  input logic cmd_valid_o
);
  localparam int unsigned QUIET = SYNC_STAGES + 3;

  logic [7:0] cs_hi_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cs_hi_cnt <= '0;
    else if (!cs_ni)         cs_hi_cnt <= '0;
    else if (cs_hi_cnt != '1) cs_hi_cnt <= cs_hi_cnt + 1'b1;
  end

  assert_one_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reg_we_o, reg_re_o, cmd_valid_o}));

  assert_we_single_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  assert_cmd_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);

  assert_re_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_o |=> !reg_re_o);

  assert_idle_no_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_hi_cnt > 8'(QUIET)) |-> !(reg_we_o || cmd_valid_o || reg_re_o));
endmodule

bind spi_reg_slave spi_reg_slave_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_ni       (cs_ni),
  .reg_we_o    (reg_we_o),
  .reg_re_o    (reg_re_o),
  .cmd_valid_o (cmd_valid_o)
);

// File: tb/sim_spi_reg_slave.sv
`timescale 1ns/1ps
module sim_spi_reg_slave;
  localparam int HALF = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic       miso, we, re, clr, cmd_v;
  logic [4:0] addr, code;
  logic [7:0] wdata, rdata;

  int n_checks = 0, n_fail = 0;
  int we_cnt = 0, cmd_cnt = 0, clr_cnt = 0, miso_hi_moves = 0, overlap = 0;
  logic [4:0] last_code = '0;
  logic [7:0] rf [32];
  logic [7:0] exp_rf [32];

  always #2 clk = ~clk;

  spi_reg_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .reg_we_o(we), .reg_re_o(re), .rd_clr_o(clr),
    .reg_addr_o(addr), .reg_wdata_o(wdata), .reg_rdata_i(rdata),
    .cmd_valid_o(cmd_v), .cmd_code_o(code)
  );

  // register file owner model
  assign rdata = rf[addr];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) rf[i] <= 8'(i) ^ 8'h5A;
    end else if (we) rf[addr] <= wdata;
    else if (clr)    rf[addr] <= 8'h00;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (we) we_cnt++;
      if (clr) clr_cnt++;
      if (cmd_v) begin cmd_cnt++; last_code = code; end
      if ((int'(we) + int'(re) + int'(cmd_v)) > 1) overlap++;
    end
  end
  always @(miso) if (sclk === 1'b1) miso_hi_moves++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - n; i--) begin
      mosi = tx[i];
      wclk(HALF);
      sclk = 1'b1;
      rx[i] = miso;
      wclk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    bits(tx, 8, rx);
  endtask

  task automatic open_t();
    cs_n = 1'b0; wclk(HALF);
  endtask

  task automatic close_t();
    wclk(HALF); cs_n = 1'b1; wclk(4 * HALF);
  endtask

  function automatic logic [7:0] val(input int a);
    return 8'((a * 37 + 11) & 8'hFF);
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    logic [7:0] rx;
    for (int i = 0; i < 32; i++) exp_rf[i] = 8'(i) ^ 8'h5A;
    wclk(5);
    // R8 reset state
    chk("R8 we", 32'(we), 0);
    chk("R8 re", 32'(re), 0);
    chk("R8 cmd", 32'(cmd_v), 0);
    chk("R8 miso", 32'(miso), 0);
    rst_n = 1'b1;
    wclk(5);

    // R1 R3: single-address writes, two per transaction
    for (int a = 0; a < 32; a += 2) begin
      open_t();
      xfer(8'(a), rx);       xfer(val(a), rx);
      xfer(8'(a + 1), rx);   xfer(val(a + 1), rx);
      close_t();
      exp_rf[a] = val(a); exp_rf[a + 1] = val(a + 1);
    end
    chk("R1 write count", 32'(we_cnt), 32);
    for (int a = 0; a < 32; a++) chk("R1 R3 reg content", 32'(rf[a]), 32'(exp_rf[a]));

    // R4 R5: continuous read of 33 bytes wrapping to 0
    open_t();
    xfer(8'h60, rx);
    for (int k = 0; k < 33; k++) begin
      xfer(8'h00, rx);
      chk("R4 R5 cont read", 32'(rx), 32'(exp_rf[k % 32]));
    end
    close_t();
    exp_rf[12] = 8'h00; exp_rf[15] = 8'h00;
    chk("R6 clr after cont read", 32'(clr_cnt), 2);
    chk("R6 reg 12 cleared", 32'(rf[12]), 0);
    chk("R6 reg 15 cleared", 32'(rf[15]), 0);

    // R6 R3: clear-on-read vs plain read, single-address alternation
    open_t();
    xfer(8'h4C, rx); xfer(8'h00, rx);
    chk("R6 reread cleared reg", 32'(rx), 0);
    xfer(8'h45, rx); xfer(8'h00, rx);
    chk("R6 plain read 1", 32'(rx), 32'(exp_rf[5]));
    xfer(8'h45, rx); xfer(8'h00, rx);
    chk("R3 R6 plain read 2", 32'(rx), 32'(exp_rf[5]));
    close_t();
    chk("R6 clr count", 32'(clr_cnt), 3);

    // R4 continuous write across the wrap
    open_t();
    xfer(8'h3E, rx);
    for (int k = 0; k < 4; k++) xfer(8'hC1 + 8'(k), rx);
    close_t();
    exp_rf[30] = 8'hC1; exp_rf[31] = 8'hC2; exp_rf[0] = 8'hC3; exp_rf[1] = 8'hC4;
    for (int a = 0; a < 32; a++) chk("R4 wrap write", 32'(rf[a]), 32'(exp_rf[a]));

    // R7 partial data word and partial header
    we_cnt = 0;
    open_t();
    xfer(8'h07, rx); bits(8'hFF, 4, rx);
    close_t();
    open_t();
    bits(8'h08, 5, rx);
    close_t();
    open_t();
    xfer(8'h09, rx); xfer(8'h99, rx);
    close_t();
    exp_rf[9] = 8'h99;
    chk("R7 partial not written", 32'(rf[7]), 32'(exp_rf[7]));
    chk("R7 next txn header", 32'(rf[9]), 32'h99);
    chk("R7 write count", 32'(we_cnt), 1);

    // R2 direct command, trailing words ignored
    open_t();
    xfer(8'h93, rx); xfer(8'h47, rx); xfer(8'h00, rx);
    close_t();
    chk("R2 cmd count", 32'(cmd_cnt), 1);
    chk("R2 cmd code", 32'(last_code), 32'h13);
    chk("R2 no write", 32'(we_cnt), 1);
    for (int a = 0; a < 32; a++) chk("R2 regs untouched", 32'(rf[a]), 32'(exp_rf[a]));

    chk("R5 miso still while sclk high", 32'(miso_hi_moves), 0);
    chk("R9 strobe overlap", 32'(overlap), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule